// File: doc/BRIEF.md
# Board Control Register File with Interrupt Aggregation

This block is a small memory-mapped register file for a board-level controller. A host reaches it over a simple synchronous 16-bit register bus: an address, a read strobe, a write strobe, write data and registered read data. It collects 32 level-sensitive interrupt inputs and passes them through a two-flop synchronizer. Their synchronized levels can be read in two 16-bit status words. Two 16-bit mask words gate them, and any source that is active and unmasked pulls a single active-low combined interrupt line to the host.

The same register space holds several board-control functions. Two device-reset words drive reset lines to peripherals; bit 2 of the first word holds the Ethernet controller in reset, and that controller's interrupt arrives on source 15. One bit switches the display backlight. Four read-only words return the state of the board's configuration switches. One read-only word reports three clock-mode strap pins. A fixed version word returns the processor-board and base-board revisions. The host unmasks sources one by one after reset. Its interrupt handler reads both status halves, discards the masked bits and services what remains.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset both mask words read 0xFFFF, the first device-reset word reads 0x0004 (the Ethernet reset, bit 2, is asserted), the second reads 0x0000, the backlight bit is 0, and `irq_n` is high.
- R2: The status word at byte offset 0x0020 returns sources 0..15 in bits 0..15, and the word at 0x0022 returns sources 16..31 in bits 0..15. A level applied to `irq_src` is visible there and on `irq_n` after two rising clock edges.
- R3: The mask words at 0x0030 (sources 0..15) and 0x0032 (sources 16..31) are read/write. A 1 blocks its source from `irq_n` and a 0 passes it.
- R4: `irq_n` is low for every cycle in which at least one synchronized source is high and unmasked, and high otherwise. It is a level, not a pulse.
- R5: A mask write changes `irq_n` right after the clock edge that takes the write.
- R6: Writes to either status word have no effect. The status word still returns the source levels, and the masks are unchanged.
- R7: The device-reset words at 0x10D0 and 0x10D2 are 16-bit read/write and drive `dev_rst1` and `dev_rst2` directly. Bit 2 of `dev_rst1` is the Ethernet controller reset.
- R8: Bit 0 of the word at 0x10B4 is read/write and drives `backlight_en`. Its other bits read as 0.
- R9: The read-only words at 0x0070, 0x0072, 0x0074 and 0x0076 return `sw_in[15:0]`, `[31:16]`, `[47:32]` and `[63:48]`. Writes to them have no effect.
- R10: The read-only word at 0x10E0 returns `boot_mode[2:0]` in bits 10:8 and 0 in every other bit.
- R11: The read-only word at 0x1100 returns the processor-board revision in bits 15:8 and the base-board revision in bits 7:0. Both revisions are parameters.
- R12: Reads of any other address, odd addresses included, return 0, and writes to them change no register.
- R13: Read data appears on `bus_rdata` in the cycle after the read strobe. `bus_rdata` is 0 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_src | input | 2*DW | Level-sensitive interrupt sources, asynchronous |
| irq_n | output | 1 | Combined interrupt, active low |
| sw_in | input | 4*DW | Configuration switch states, four banks |
| boot_mode | input | 3 | Clock-mode strap pins |
| dev_rst1 | output | DW | First device-reset word, bit 2 resets the Ethernet controller |
| dev_rst2 | output | DW | Second device-reset word |
| backlight_en | output | 1 | Display backlight enable |

## Verification
A wrong mask bit shows on `irq_n` at once: the line stays high for a source that should pass, or drops for one that should be blocked, in the cycle right after the mask write. A synchronizer that is one stage too long or too short moves the edges of `irq_n` and of the status readback off the two-edge latency, so the bench checks the line one edge early and again exactly on time. A bad address decode or register enable shows in the readback of a neighbouring word after a write, and in the reset and backlight pins. Any such fault is visible on the next read.

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter int ADDR_W = 13,
  parameter int DW = 16,
  parameter logic [7:0] CPU_REV = 8'h01,
  parameter logic [7:0] BASE_REV = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [2*DW-1:0]   irq_src,
  output logic              irq_n,
  input  logic [4*DW-1:0]   sw_in,
  input  logic [2:0]        boot_mode,
  output logic [DW-1:0]     dev_rst1,
  output logic [DW-1:0]     dev_rst2,
  output logic              backlight_en
);
  localparam int NSRC = 2 * DW;
  localparam logic [ADDR_W-1:0] A_STAT_LO = ADDR_W'('h0020);
  localparam logic [ADDR_W-1:0] A_STAT_HI = ADDR_W'('h0022);
  localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'('h0030);
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'('h0032);
  localparam logic [ADDR_W-1:0] A_SW0     = ADDR_W'('h0070);
  localparam logic [ADDR_W-1:0] A_SW1     = ADDR_W'('h0072);
  localparam logic [ADDR_W-1:0] A_SW2     = ADDR_W'('h0074);
  localparam logic [ADDR_W-1:0] A_SW3     = ADDR_W'('h0076);
  localparam logic [ADDR_W-1:0] A_BLIGHT  = ADDR_W'('h10B4);
  localparam logic [ADDR_W-1:0] A_RST1    = ADDR_W'('h10D0);
  localparam logic [ADDR_W-1:0] A_RST2    = ADDR_W'('h10D2);
  localparam logic [ADDR_W-1:0] A_BOOT    = ADDR_W'('h10E0);
  localparam logic [ADDR_W-1:0] A_VER     = ADDR_W'('h1100);
  localparam logic [DW-1:0]     RST1_INIT = DW'(4);

  logic [NSRC-1:0] sync_s1, irq_sync;
  logic [DW-1:0]   mask_lo, mask_hi;
  logic [NSRC-1:0] mask_q;
  logic [DW-1:0]   rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_s1  <= '0;
      irq_sync <= '0;
    end else begin
      sync_s1  <= irq_src;
      irq_sync <= sync_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_lo      <= '1;
      mask_hi      <= '1;
      dev_rst1     <= RST1_INIT;
      dev_rst2     <= '0;
      backlight_en <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MASK_LO: mask_lo      <= bus_wdata;
        A_MASK_HI: mask_hi      <= bus_wdata;
        A_RST1:    dev_rst1     <= bus_wdata;
        A_RST2:    dev_rst2     <= bus_wdata;
        A_BLIGHT:  backlight_en <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  assign mask_q = {mask_hi, mask_lo};
  assign irq_n  = ~|(irq_sync & ~mask_q);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_STAT_LO: rd_mux = irq_sync[DW-1:0];
      A_STAT_HI: rd_mux = irq_sync[NSRC-1:DW];
      A_MASK_LO: rd_mux = mask_lo;
      A_MASK_HI: rd_mux = mask_hi;
      A_SW0:     rd_mux = sw_in[DW-1:0];
      A_SW1:     rd_mux = sw_in[2*DW-1:DW];
      A_SW2:     rd_mux = sw_in[3*DW-1:2*DW];
      A_SW3:     rd_mux = sw_in[4*DW-1:3*DW];
      A_BLIGHT:  rd_mux = DW'(backlight_en);
      A_RST1:    rd_mux = dev_rst1;
      A_RST2:    rd_mux = dev_rst2;
      A_BOOT:    rd_mux = DW'({boot_mode, 8'h00});
      A_VER:     rd_mux = DW'({CPU_REV, BASE_REV});
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_mux : '0;
  end
endmodule

module board_ctl_regs_chk #(
  parameter int ADDR_W = 13,
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_rdata,
  input logic [2*DW-1:0]   irq_src,
  input logic              irq_n,
  input logic              backlight_en,
  input logic [2*DW-1:0]   mask_q,
  input logic [2*DW-1:0]   irq_sync
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_sync_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> irq_sync == $past(irq_src, 2));

  p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> irq_n);

  p_stat_write_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && bus_wr && (bus_addr == ADDR_W'('h0020) || bus_addr == ADDR_W'('h0022)))
    |=> $stable(mask_q));

  p_blight_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !(bus_wr && bus_addr == ADDR_W'('h10B4))) |=> $stable(backlight_en));

  p_rdata_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !bus_rd) |=> bus_rdata == '0);
endmodule

bind board_ctl_regs board_ctl_regs_chk #(.ADDR_W(ADDR_W), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_n(irq_n), .backlight_en(backlight_en),
  .mask_q(mask_q), .irq_sync(irq_sync)
);

// File: tb/board_ctl_regs_tb.sv
module board_ctl_regs_tb_top;
  localparam int AW = 13;
  localparam logic [7:0] CREV = 8'h3C;
  localparam logic [7:0] BREV = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [31:0] irq_src = '0;
  logic irq_n;
  logic [63:0] sw_in = 64'h0;
  logic [2:0] boot_mode = 3'b000;
  logic [15:0] dev_rst1, dev_rst2;
  logic backlight_en;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  board_ctl_regs #(.ADDR_W(AW), .DW(16), .CPU_REV(CREV), .BASE_REV(BREV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_n(irq_n),
    .sw_in(sw_in), .boot_mode(boot_mode), .dev_rst1(dev_rst1), .dev_rst2(dev_rst2),
    .backlight_en(backlight_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk); irq_src = v;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irq_n", irq_n, 1);
    check("R1 dev_rst1 pin", dev_rst1, 16'h0004);
    check("R1 dev_rst2 pin", dev_rst2, 0);
    check("R1 backlight pin", backlight_en, 0);
    check("R13 idle rdata", bus_rdata, 0);
    rd(13'h0030, d); check("R1 mask lo", d, 16'hFFFF);
    rd(13'h0032, d); check("R1 mask hi", d, 16'hFFFF);
    rd(13'h10D0, d); check("R1 rst1 read", d, 16'h0004);
    rd(13'h10D2, d); check("R1 rst2 read", d, 0);
    rd(13'h10B4, d); check("R1 backlight read", d, 0);
  endtask

  task automatic t_status();
    logic [15:0] d;
    set_src(32'hA5A5_0F0F);
    rd(13'h0020, d); check("R2 status lo", d, 16'h0F0F);
    rd(13'h0022, d); check("R2 status hi", d, 16'hA5A5);
    check("R3 masked irq_n", irq_n, 1);
    set_src(32'h0000_0000);
    rd(13'h0020, d); check("R2 status lo clear", d, 0);
  endtask

  task automatic t_latency();
    wr(13'h0030, 16'h0000);
    @(negedge clk); irq_src = 32'h0000_0080;
    @(posedge clk); @(negedge clk); check("R2 one edge early", irq_n, 1);
    @(posedge clk); @(negedge clk); check("R2 two edges", irq_n, 0);
    @(negedge clk); irq_src = 32'h0;
    @(posedge clk); @(negedge clk); check("R4 still low one edge", irq_n, 0);
    @(posedge clk); @(negedge clk); check("R4 released", irq_n, 1);
    wr(13'h0030, 16'hFFFF);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    set_src(32'h0000_8000);
    check("R3 eth masked", irq_n, 1);
    wr(13'h0030, 16'h7FFF);
    check("R5 unmask immediate", irq_n, 0);
    rd(13'h0030, d); check("R3 mask lo readback", d, 16'h7FFF);
    repeat (5) @(negedge clk);
    check("R4 level held", irq_n, 0);
    wr(13'h0030, 16'hFFFF);
    check("R5 remask immediate", irq_n, 1);
    wr(13'h0030, 16'h7FFF);
    set_src(32'h0010_0000);
    check("R4 src15 gone, src20 masked", irq_n, 1);
    wr(13'h0032, 16'hFFEF);
    check("R5 hi unmask", irq_n, 0);
    rd(13'h0032, d); check("R3 mask hi readback", d, 16'hFFEF);
    wr(13'h0032, 16'hFFFF); wr(13'h0030, 16'hFFFF);
    set_src(32'h0);
  endtask

  task automatic t_status_ro();
    logic [15:0] d;
    set_src(32'h0001_0003);
    wr(13'h0020, 16'h1234);
    wr(13'h0022, 16'hFFFF);
    rd(13'h0020, d); check("R6 status lo after write", d, 16'h0003);
    rd(13'h0022, d); check("R6 status hi after write", d, 16'h0001);
    rd(13'h0030, d); check("R6 mask untouched", d, 16'hFFFF);
    check("R6 irq_n", irq_n, 1);
    set_src(32'h0);
  endtask

  task automatic t_resets();
    logic [15:0] d;
    wr(13'h10D0, 16'h0000);
    check("R7 eth released", dev_rst1[2], 0);
    wr(13'h10D2, 16'hBEEF);
    check("R7 rst2 pin", dev_rst2, 16'hBEEF);
    rd(13'h10D2, d); check("R7 rst2 read", d, 16'hBEEF);
    wr(13'h10D0, 16'h0004);
    check("R7 eth reset pin", dev_rst1, 16'h0004);
    rd(13'h10D0, d); check("R7 rst1 read", d, 16'h0004);
  endtask

  task automatic t_backlight();
    logic [15:0] d;
    wr(13'h10B4, 16'hFFFF);
    check("R8 backlight on", backlight_en, 1);
    rd(13'h10B4, d); check("R8 upper bits zero", d, 16'h0001);
    wr(13'h10B4, 16'hFFFE);
    check("R8 backlight off", backlight_en, 0);
  endtask

  task automatic t_switch_boot_ver();
    logic [15:0] d;
    sw_in = 64'h4444_3333_2222_1111;
    boot_mode = 3'b101;
    rd(13'h0070, d); check("R9 bank0", d, 16'h1111);
    rd(13'h0072, d); check("R9 bank1", d, 16'h2222);
    rd(13'h0074, d); check("R9 bank2", d, 16'h3333);
    rd(13'h0076, d); check("R9 bank3", d, 16'h4444);
    wr(13'h0070, 16'h0000);
    rd(13'h0070, d); check("R9 write ignored", d, 16'h1111);
    rd(13'h10E0, d); check("R10 boot mode", d, 16'h0500);
    wr(13'h1100, 16'h0000);
    rd(13'h1100, d); check("R11 version", d, {CREV, BREV});
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    rd(13'h0024, d); check("R12 unmapped read", d, 0);
    rd(13'h0031, d); check("R12 odd read", d, 0);
    wr(13'h0031, 16'h0000);
    wr(13'h10B5, 16'h0001);
    wr(13'h10D1, 16'h0000);
    rd(13'h0030, d); check("R12 mask lo kept", d, 16'hFFFF);
    check("R12 backlight kept", backlight_en, 0);
    check("R12 rst1 kept", dev_rst1, 16'h0004);
  endtask

  task automatic t_rd_timing();
    logic [15:0] d;
    rd(13'h1100, d); check("R13 read data", d, {CREV, BREV});
    @(posedge clk); @(negedge clk);
    check("R13 zero after read", bus_rdata, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_latency();
    t_mask();
    t_status_ro();
    t_resets();
    t_backlight();
    t_switch_boot_ver();
    t_unmapped();
    t_rd_timing();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule